// File: doc/BRIEF.md
# Linked-List DMA Descriptor Fetcher

This block sequences one channel of a linked-list DMA engine. Each time the datapath reports that a block copy has finished, the fetcher decides whether the channel continues. If it does, the fetcher reads a four-word descriptor from memory through a single-word read port. The descriptor words land in the channel's count, source, destination and link registers, and the fetcher then tells the datapath to start the next block. If the chain is over, the fetcher tidies the control register, optionally latches a completion interrupt, and signals that the channel has finished.

Software programs the channel through a small register port: a control word, the four descriptor registers and an interrupt-state register. The link register decides where the next descriptor lives. A zero link, or the control bit that selects single-block operation, makes the next done pulse finish the chain rather than fetch.

Top module: `desc_chain_fetch`

## Requirements
- R1: After reset every register reads as zero, and `irq`, `mem_rd_req`, `blk_start` and `chain_end` are low.
- R2: A `blk_done` pulse while idle, with control bit 9 clear and a nonzero link, makes four reads in turn at link, link+4, link+8 and link+12. Each read keeps `mem_rd_req` high and `mem_rd_addr` steady until the cycle where `mem_rd_valid` is high.
- R3: The four fetched words are written, in fetch order, to count (address 1), source (address 2), destination (address 3) and link (address 4). The read port returns these registers combinationally.
- R4: `blk_start` is high for exactly one cycle: the cycle after the clock edge that accepts the fourth word.
- R5: A `blk_done` pulse while idle with a zero link issues no read, and `chain_end` is high for one cycle, the cycle after that pulse is sampled.
- R6: With control bit 9 set, `blk_done` ends the chain as in R5 even when the link is nonzero, and the link register keeps its value.
- R7: At chain end, control bits 12 and 14 are cleared and all other control bits are kept. The clear takes priority over a software write to control (address 0) in the same cycle.
- R8: At chain end, bit `CH_IDX` of the interrupt-state register (address 5) is set if control bit 10 was set, and is left unchanged otherwise.
- R9: An interrupt-state bit stays set until software writes a 1 to that bit position of address 5. Writing 0 there has no effect. `irq` is the OR of all interrupt-state bits.
- R10: A software write to the link register while idle is used as the address of the next fetch. Writes to the count, source, destination or link registers during a fetch are ignored.
- R11: A `blk_done` pulse that arrives during a fetch is ignored: no extra reads take place and no extra `blk_start` or `chain_end` pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read address |
| reg_rd_data | output | 32 | Register read data (combinational) |
| blk_done | input | 1 | One-cycle pulse: datapath finished a block |
| mem_rd_req | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 32 | Descriptor word byte address |
| mem_rd_valid | input | 1 | Read data valid; completes the current request |
| mem_rd_data | input | 32 | Read data word |
| blk_start | output | 1 | One-cycle pulse: run the next block |
| chain_end | output | 1 | One-cycle pulse: chain finished |
| irq | output | 1 | OR of the interrupt-state bits |

## Verification
The hardest situations to reach from the ports are traffic that arrives in the middle of a descriptor fetch. A software write to a descriptor register, or a stray done pulse, must land while the read handshake is stalled between words. The bench brings these about with a memory responder whose wait-state count it sets itself. With three wait states, each word stays outstanding long enough for the bench to inject both events at a known point. The bench then checks that the fetched values win, that exactly four reads occur, and that the start pulse appears on the cycle predicted by the formula 8 + 4 x wait-states.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
    localparam int WORD_W     = 32;
    localparam int RA_W       = 3;
    localparam int WORD_BYTES = 4;

    // register map
    typedef enum logic [RA_W-1:0] {
        RA_CTRL  = 3'd0,
        RA_COUNT = 3'd1,
        RA_SRC   = 3'd2,
        RA_DST   = 3'd3,
        RA_LINK  = 3'd4,
        RA_INTST = 3'd5
    } reg_addr_e;

    // control bit positions
    localparam int CB_SINGLE = 9;
    localparam int CB_IRQ_EN = 10;
    localparam int CB_ACT_A  = 12;
    localparam int CB_ACT_B  = 14;

    // descriptor word order
    localparam logic [1:0] W_COUNT = 2'd0;
    localparam logic [1:0] W_SRC   = 2'd1;
    localparam logic [1:0] W_DST   = 2'd2;
    localparam logic [1:0] W_LINK  = 2'd3;

    typedef enum logic {ST_IDLE, ST_FETCH} seq_st_e;

    typedef struct packed {
        logic [WORD_W-1:0] count;
        logic [WORD_W-1:0] src;
        logic [WORD_W-1:0] dst;
        logic [WORD_W-1:0] link;
    } desc_t;

    function automatic logic [WORD_W-1:0] end_keep_mask();
        logic [WORD_W-1:0] m;
        m = '1;
        m[CB_ACT_A] = 1'b0;
        m[CB_ACT_B] = 1'b0;
        return m;
    endfunction

    function automatic logic chain_stops(input logic [WORD_W-1:0] ctrl,
                                         input logic [WORD_W-1:0] link);
        return ctrl[CB_SINGLE] || (link == '0);
    endfunction
endpackage

// File: rtl/dcf_seq.sv
`timescale 1ns/1ps
module dcf_seq
    import dcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              blk_done,
    input  logic [WORD_W-1:0] ctrl,
    input  logic [WORD_W-1:0] link,
    output logic              mem_rd_req,
    output logic [WORD_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              ld_en,
    output logic [1:0]        ld_sel,
    output logic [WORD_W-1:0] ld_data,
    output logic              fin,
    output logic              busy,
    output logic              blk_start,
    output logic              chain_end
);
    seq_st_e           st;
    logic [WORD_W-1:0] ptr;
    logic [1:0]        idx;

    always_comb begin
        busy        = (st == ST_FETCH);
        mem_rd_req  = busy;
        mem_rd_addr = ptr;
        ld_en       = busy && mem_rd_valid;
        ld_sel      = idx;
        ld_data     = mem_rd_data;
        fin         = (st == ST_IDLE) && blk_done && chain_stops(ctrl, link);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ptr       <= '0;
            idx       <= W_COUNT;
            blk_start <= 1'b0;
            chain_end <= 1'b0;
        end else begin
            blk_start <= 1'b0;
            chain_end <= fin;
            case (st)
                ST_IDLE: begin
                    if (blk_done && !chain_stops(ctrl, link)) begin
                        st  <= ST_FETCH;
                        ptr <= link;
                        idx <= W_COUNT;
                    end
                end
                default: begin
                    if (mem_rd_valid) begin
                        ptr <= ptr + WORD_W'(WORD_BYTES);
                        idx <= idx + 2'd1;
                        if (idx == W_LINK) begin
                            st        <= ST_IDLE;
                            blk_start <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && mem_rd_valid && idx != W_LINK) |=>
            (mem_rd_addr == $past(mem_rd_addr) + WORD_W'(WORD_BYTES)));

    // R4
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        blk_start |-> $past(mem_rd_req && mem_rd_valid));

    // R5
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(blk_start && chain_end));

    // R11
    done_in_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && blk_done) |-> !fin);
endmodule

// File: rtl/dcf_regs.sv
`timescale 1ns/1ps
module dcf_regs
    import dcf_pkg::*;
#(
    parameter int INT_W  = 4,
    parameter int CH_IDX = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              busy,
    input  logic              ld_en,
    input  logic [1:0]        ld_sel,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              fin,
    output logic [WORD_W-1:0] ctrl,
    output logic [WORD_W-1:0] link,
    output logic              irq
);
    localparam int PAD_W = WORD_W - INT_W;

    desc_t             desc, desc_d;
    logic [WORD_W-1:0] ctrl_d;
    logic [INT_W-1:0]  int_st, int_d;

    always_comb begin
        ctrl_d = ctrl;
        desc_d = desc;
        int_d  = int_st;
        if (wr_en) begin
            case (wr_addr)
                RA_CTRL:  ctrl_d = wr_data;
                RA_COUNT: if (!busy) desc_d.count = wr_data;
                RA_SRC:   if (!busy) desc_d.src   = wr_data;
                RA_DST:   if (!busy) desc_d.dst   = wr_data;
                RA_LINK:  if (!busy) desc_d.link  = wr_data;
                RA_INTST: int_d = int_st & ~wr_data[INT_W-1:0];
                default: ;
            endcase
        end
        if (ld_en) begin
            case (ld_sel)
                W_COUNT: desc_d.count = ld_data;
                W_SRC:   desc_d.src   = ld_data;
                W_DST:   desc_d.dst   = ld_data;
                default: desc_d.link  = ld_data;
            endcase
        end
        if (fin) begin
            ctrl_d = ctrl_d & end_keep_mask();
            if (ctrl[CB_IRQ_EN]) int_d[CH_IDX] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            desc   <= '0;
            int_st <= '0;
        end else begin
            ctrl   <= ctrl_d;
            desc   <= desc_d;
            int_st <= int_d;
        end
    end

    always_comb begin
        case (rd_addr)
            RA_CTRL:  rd_data = ctrl;
            RA_COUNT: rd_data = desc.count;
            RA_SRC:   rd_data = desc.src;
            RA_DST:   rd_data = desc.dst;
            RA_LINK:  rd_data = desc.link;
            RA_INTST: rd_data = {{PAD_W{1'b0}}, int_st};
            default:  rd_data = '0;
        endcase
    end

    assign link = desc.link;
    assign irq  = |int_st;

    // R9
    int_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (int_st[CH_IDX] && !(wr_en && wr_addr == RA_INTST && wr_data[CH_IDX]))
            |=> int_st[CH_IDX]);

    // R7
    end_clear_chk: assert property (@(posedge clk) disable iff (rst)
        fin |=> (!ctrl[CB_ACT_A] && !ctrl[CB_ACT_B]));

    // R8
    no_irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        (fin && !ctrl[CB_IRQ_EN] && !int_st[CH_IDX]) |=> !int_st[CH_IDX]);

    // R10
    desc_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !ld_en) |=> $stable(desc));
endmodule

// File: rtl/desc_chain_fetch.sv
`timescale 1ns/1ps
module desc_chain_fetch
    import dcf_pkg::*;
#(
    parameter int INT_W  = 4,
    parameter int CH_IDX = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [RA_W-1:0]   reg_wr_addr,
    input  logic [WORD_W-1:0] reg_wr_data,
    input  logic [RA_W-1:0]   reg_rd_addr,
    output logic [WORD_W-1:0] reg_rd_data,
    input  logic              blk_done,
    output logic              mem_rd_req,
    output logic [WORD_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              blk_start,
    output logic              chain_end,
    output logic              irq
);
    logic [WORD_W-1:0] ctrl, link, ld_data;
    logic              ld_en, fin, busy;
    logic [1:0]        ld_sel;

    dcf_seq u_seq (
        .clk, .rst, .blk_done, .ctrl, .link,
        .mem_rd_req, .mem_rd_addr, .mem_rd_valid, .mem_rd_data,
        .ld_en, .ld_sel, .ld_data, .fin, .busy, .blk_start, .chain_end
    );

    dcf_regs #(.INT_W(INT_W), .CH_IDX(CH_IDX)) u_regs (
        .clk, .rst,
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
        .busy, .ld_en, .ld_sel, .ld_data, .fin, .ctrl, .link, .irq
    );

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> chain_end);
endmodule

// File: tb/desc_chain_fetch_tb.sv
`timescale 1ns/1ps
module desc_chain_fetch_tb;
    import dcf_pkg::*;
    localparam int INT_W  = 4;
    localparam int CH_IDX = 1;

    logic        clk = 1'b0, rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0, reg_rd_addr = '0;
    logic [31:0] reg_wr_data = '0, reg_rd_data, mem_rd_addr;
    logic        blk_done = 1'b0, mem_rd_req, mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        blk_start, chain_end, irq;

    int checks = 0, errors = 0, lat = 0, nacc = 0, wcnt = 0;
    logic [31:0] mem [0:63];
    logic [31:0] acc_addr [0:7];

    always #2 clk = ~clk;

    desc_chain_fetch #(.INT_W(INT_W), .CH_IDX(CH_IDX)) u_dut (.*);

    function automatic logic [31:0] daddr(input int k);
        return 32'hC0 - 32'(k) * 32'h20;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic build_mem(input int len);
        for (int i = 0; i < 64; i++) mem[i] = 32'hFFFF_FFFF;
        for (int k = 0; k < len; k++) begin
            mem[daddr(k) >> 2]       = 32'h1000 + 32'(k);
            mem[(daddr(k) >> 2) + 1] = 32'h2000_0000 + 32'(k) * 32'h11;
            mem[(daddr(k) >> 2) + 2] = 32'h3000_0000 + 32'(k) * 32'h101;
            mem[(daddr(k) >> 2) + 3] = (k < len - 1) ? daddr(k + 1) : 32'h0;
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd_addr = a;
        #1;
        d = reg_rd_data;
    endtask

    task automatic pulse_done();
        blk_done = 1'b1;
        @(negedge clk);
        blk_done = 1'b0;
    endtask

    task automatic wait_evt(output int cyc, output bit gs, output bit ge);
        cyc = 1; gs = 0; ge = 0;
        while (cyc < 200) begin
            if (blk_start) begin gs = 1; break; end
            if (chain_end) begin ge = 1; break; end
            @(negedge clk);
            cyc++;
        end
    endtask

    // memory responder with programmable wait states
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_valid) mem_rd_valid = 1'b0;
            else if (mem_rd_req) begin
                if (wcnt >= lat) begin
                    mem_rd_valid = 1'b1;
                    mem_rd_data  = mem[mem_rd_addr[7:2]];
                    if (nacc < 8) acc_addr[nacc] = mem_rd_addr;
                    nacc++;
                    wcnt = 0;
                end else wcnt++;
            end
        end
    end

    task automatic check_block(input int k, input int cyc, input bit gs);
        logic [31:0] v;
        chk("R4 start seen", 32'(gs), 32'd1);
        chk("R4 start cycle", 32'(cyc), 32'(8 + 4 * lat));
        chk("R2 read count", 32'(nacc), 32'd4);
        for (int i = 0; i < 4; i++)
            chk("R2 read address", acc_addr[i], daddr(k) + 32'(4 * i));
        rd(RA_COUNT, v); chk("R3 count", v, mem[daddr(k) >> 2]);
        rd(RA_SRC, v);   chk("R3 source", v, mem[(daddr(k) >> 2) + 1]);
        rd(RA_DST, v);   chk("R3 destination", v, mem[(daddr(k) >> 2) + 2]);
        rd(RA_LINK, v);  chk("R3 link", v, mem[(daddr(k) >> 2) + 3]);
        @(negedge clk);
        chk("R4 one-cycle pulse", 32'(blk_start), 32'd0);
    endtask

    task automatic run_chain(input int len, input bit ien);
        logic [31:0] c0, v;
        int cyc; bit gs, ge;
        build_mem(len);
        c0 = 32'h0000_5081 | (32'(ien) << CB_IRQ_EN);
        wr(RA_INTST, 32'hF);
        wr(RA_CTRL, c0);
        wr(RA_LINK, daddr(0));   // R10: idle link write steers fetch
        for (int k = 0; k < len; k++) begin
            nacc = 0;
            pulse_done();
            wait_evt(cyc, gs, ge);
            check_block(k, cyc, gs);
        end
        nacc = 0;
        pulse_done();
        wait_evt(cyc, gs, ge);
        chk("R5 end seen", 32'(ge), 32'd1);
        chk("R5 end cycle", 32'(cyc), 32'd1);
        chk("R5 no reads", 32'(nacc), 32'd0);
        rd(RA_CTRL, v);  chk("R7 control cleanup", v, c0 & ~32'h5000);
        rd(RA_INTST, v); chk("R8 int state", v, 32'(ien) << CH_IDX);
        chk("R9 irq", 32'(irq), 32'(ien));
        @(negedge clk);
        chk("R5 one-cycle end", 32'(chain_end), 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        int cyc; bit gs, ge;
        repeat (3) @(negedge clk);
        // R1
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v); chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset outputs", {28'h0, irq, mem_rd_req, blk_start, chain_end}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        for (int l = 0; l < 4; l++)
            for (int n = 1; n <= 3; n++)
                for (int e = 0; e < 2; e++) begin
                    lat = l;
                    run_chain(n, e[0]);
                end

        // R6 single-block mode with nonzero link
        build_mem(2);
        wr(RA_INTST, 32'hF);
        wr(RA_CTRL, 32'h0000_5600);
        wr(RA_LINK, daddr(0));
        nacc = 0;
        pulse_done();
        wait_evt(cyc, gs, ge);
        chk("R6 end seen", 32'(ge), 32'd1);
        chk("R6 no reads", 32'(nacc), 32'd0);
        rd(RA_LINK, v); chk("R6 link kept", v, daddr(0));
        rd(RA_CTRL, v); chk("R6 R7 control", v, 32'h0000_0600);

        // R9 write-one-to-clear
        @(negedge clk);
        wr(RA_INTST, 32'h0);
        rd(RA_INTST, v); chk("R9 write 0 keeps", v, 32'h1 << CH_IDX);
        chk("R9 irq held", 32'(irq), 32'd1);
        wr(RA_INTST, 32'h1 << CH_IDX);
        rd(RA_INTST, v); chk("R9 write 1 clears", v, 32'h0);
        chk("R9 irq low", 32'(irq), 32'd0);

        // R10 / R11: disturbance during a stalled fetch
        lat = 3;
        build_mem(3);
        @(negedge clk);
        wr(RA_CTRL, 32'h0);
        wr(RA_LINK, daddr(1));
        nacc = 0;
        pulse_done();
        @(negedge clk);
        wr(RA_COUNT, 32'hDEAD_BEEF);
        wr(RA_LINK, 32'h0000_0004);
        pulse_done();
        wait_evt(cyc, gs, ge);
        chk("R10 R4 start after disturbance", 32'(gs), 32'd1);
        chk("R10 R4 start cycle", 32'(cyc), 32'(8 + 4 * lat - 4));
        rd(RA_COUNT, v); chk("R10 count from memory", v, mem[daddr(1) >> 2]);
        rd(RA_LINK, v);  chk("R10 link from memory", v, daddr(2));
        chk("R10 first address", acc_addr[0], daddr(1));
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (blk_start || chain_end || mem_rd_req) begin
                chk("R11 no extra activity", 32'h1, 32'h0);
                break;
            end
        end
        chk("R11 read count", 32'(nacc), 32'd4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule